// File: doc/BRIEF.md
# Combined Doorbell Interrupt Aggregator

This block merges the interrupt-pending signals of a set of doorbell windows into a single combined interrupt line. Each window supplies a pending level and a combine-enable level. A window takes part in the combined view only while both are high. The number of implemented windows is a parameter from 1 to 128.

Software locates the source through a small read port. The pending windows appear as a bank of four 32-bit status words. Window n sits in word n/32 at bit n mod 32, so a find-first-set scan from word 0 upward returns the lowest-numbered pending window first. The status is level-based and is never latched. A bit stays set while its window is pending and enabled, and it clears as soon as either input drops. The same port also returns a configuration word that reports the implemented window count minus one.

The bank has no write path, so software cannot alter the status view. Servicing a window therefore means clearing its pending input at the window itself.

Top module: `dbell_irq_combiner`

## Requirements
- R1: A read of address 0, 1, 2 or 3 returns status word k = address. Bit b of word k reflects window k*32+b.
- R2: A window's status bit is 1 only while both its pending input and its combine-enable input are 1. A window with combine-enable 0 sets neither a status bit nor the interrupt.
- R3: Status bits for window numbers at or above NUM_WIN always read 0.
- R4: A read of address 4 returns the configuration word. Bits [7:0] hold NUM_WIN-1 and bits [31:8] are 0.
- R5: irq_o is the OR of all status bits, registered once. It rises on the first clock edge after a bit becomes set and falls on the first clock edge after the last bit clears.
- R6: A status bit is level-based. It stays set across repeated reads while its inputs hold, and it clears only when its pending input (or its enable) drops.
- R7: Read data appears on rd_data_o one clock edge after rd_en_i is sampled high, with rd_valid_o high for exactly that cycle. Reads of addresses 5, 6 and 7 return 0.
- R8: While rst_ni is low, irq_o, rd_valid_o and rd_data_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pend_i | input | NUM_WIN | Per-window interrupt-pending level |
| comb_en_i | input | NUM_WIN | Per-window combine-enable level |
| rd_en_i | input | 1 | Read request, one cycle per read |
| rd_addr_i | input | 3 | Read word address: 0-3 status, 4 configuration |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |
| rd_data_o | output | 32 | Read data |
| irq_o | output | 1 | Combined interrupt, registered |

## Verification
The bench walks single pending windows across the word boundaries (0, 31, 32, 63, 64, 95, 96 and the last implemented window). These cases separate a correct word/bit split from an off-by-one or a swapped index. Broad patterns check that the enable vector gates each bit independently of its neighbours: alternating pending bits, interleaved enable nibbles, and all windows pending with enables off. The instance is built with a window count that ends inside the last word, so the all-ones case shows that the unimplemented bits stay zero. Held and dropped pending levels, together with timed interrupt samples, show that the status is not latched and that the line lags the inputs by exactly one edge.

// File: rtl/dbirq_pkg.sv
package dbirq_pkg;
  localparam int unsigned WORD_W      = 32;
  localparam int unsigned MAX_WIN     = 128;
  localparam int unsigned STAT_WORDS  = MAX_WIN / WORD_W;
  localparam int unsigned ADDR_W      = 3;
  localparam int unsigned CNT_W       = 8;
  localparam logic [ADDR_W-1:0] CFG_ADDR = ADDR_W'(STAT_WORDS);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [STAT_WORDS-1:0][WORD_W-1:0] stat_bank_t;

  function automatic word_t cfg_word(input int unsigned num_win);
    word_t w;
    w = '0;
    w[CNT_W-1:0] = CNT_W'(num_win - 1);
    return w;
  endfunction
endpackage

// File: rtl/dbirq_status_bank.sv
module dbirq_status_bank
  import dbirq_pkg::*;
#(
  parameter int unsigned NUM_WIN = 128
) (
  input  logic [NUM_WIN-1:0] pend_i,
  input  logic [NUM_WIN-1:0] comb_en_i,
  output stat_bank_t         stat_o
);
  for (genvar w = 0; w < STAT_WORDS; w++) begin : g_word
    for (genvar b = 0; b < WORD_W; b++) begin : g_bit
      localparam int unsigned IDX = w * WORD_W + b;
      if (IDX < NUM_WIN) begin : g_live
        assign stat_o[w][b] = pend_i[IDX] & comb_en_i[IDX];
      end else begin : g_tie
        assign stat_o[w][b] = 1'b0;
      end
    end
  end
endmodule

// File: rtl/dbirq_irq_reduce.sv
module dbirq_irq_reduce
  import dbirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  stat_bank_t stat_i,
  output logic       irq_o
);
  logic [STAT_WORDS-1:0] word_any;

  for (genvar w = 0; w < STAT_WORDS; w++) begin : g_or
    assign word_any[w] = |stat_i[w];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= |word_any;
  end
endmodule

// File: rtl/dbirq_read_port.sv
module dbirq_read_port
  import dbirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  stat_bank_t        stat_i,
  input  word_t             cfg_i,
  output logic              rd_valid_o,
  output word_t             rd_data_o
);
  localparam int unsigned SEL_W = $clog2(STAT_WORDS);

  word_t rd_mux;

  always_comb begin
    rd_mux = '0;
    if (rd_addr_i < ADDR_W'(STAT_WORDS)) rd_mux = stat_i[rd_addr_i[SEL_W-1:0]];
    else if (rd_addr_i == CFG_ADDR)     rd_mux = cfg_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rd_data_o <= rd_mux;
    end
  end
endmodule

// File: rtl/dbell_irq_combiner.sv
module dbell_irq_combiner
  import dbirq_pkg::*;
#(
  parameter int unsigned NUM_WIN = 128
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_WIN-1:0] pend_i,
  input  logic [NUM_WIN-1:0] comb_en_i,
  input  logic               rd_en_i,
  input  logic [2:0]         rd_addr_i,
  output logic               rd_valid_o,
  output logic [31:0]        rd_data_o,
  output logic               irq_o
);
  stat_bank_t stat;
  word_t      cfg;

  assign cfg = cfg_word(NUM_WIN);

  dbirq_status_bank #(.NUM_WIN(NUM_WIN)) u_bank (
    .pend_i    (pend_i),
    .comb_en_i (comb_en_i),
    .stat_o    (stat)
  );

  dbirq_irq_reduce u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (stat),
    .irq_o  (irq_o)
  );

  dbirq_read_port u_rd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rd_en_i    (rd_en_i),
    .rd_addr_i  (rd_addr_i),
    .stat_i     (stat),
    .cfg_i      (cfg),
    .rd_valid_o (rd_valid_o),
    .rd_data_o  (rd_data_o)
  );
endmodule

// File: rtl/dbirq_checker.sv
module dbirq_checker #(
  parameter int unsigned NUM_WIN = 128
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_WIN-1:0] pend_i,
  input logic [NUM_WIN-1:0] comb_en_i,
  input logic               rd_en_i,
  input logic [2:0]         rd_addr_i,
  input logic               rd_valid_o,
  input logic [31:0]        rd_data_o,
  input logic               irq_o
);
  logic any_live;
  assign any_live = |(pend_i & comb_en_i);

  // R5
  a_r5_irq_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_live |=> irq_o);
  a_r5_irq_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_live |=> !irq_o);
  // R2
  a_r2_no_enable_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (comb_en_i == '0) |=> !irq_o);
  // R7
  a_r7_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o);
  a_r7_valid_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> !rd_valid_o);
  a_r7_hole_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i[2] && rd_addr_i[1:0] != 2'd0) |=> rd_data_o == 32'd0);
  // R4
  a_r4_cfg_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == 3'd4) |=> rd_data_o == 32'(NUM_WIN - 1));
  // R1
  a_r1_window0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && rd_addr_i == 3'd0) |=> rd_data_o[0] == $past(pend_i[0] & comb_en_i[0]));
  // R8
  always_comb begin
    if (!rst_ni) begin
      a_r8_reset_quiet: assert (!irq_o && !rd_valid_o && rd_data_o == 32'd0);
    end
  end
endmodule

bind dbell_irq_combiner dbirq_checker #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .pend_i     (pend_i),
  .comb_en_i  (comb_en_i),
  .rd_en_i    (rd_en_i),
  .rd_addr_i  (rd_addr_i),
  .rd_valid_o (rd_valid_o),
  .rd_data_o  (rd_data_o),
  .irq_o      (irq_o)
);

// File: tb/tb_dbell_irq_combiner.sv
module tb_dbell_irq_combiner;
  localparam int N = 100;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] pend = '0;
  logic [N-1:0] en = '0;
  logic         rd_en = 1'b0;
  logic [2:0]   rd_addr = '0;
  logic         rd_valid;
  logic [31:0]  rd_data;
  logic         irq;

  int checks = 0;
  int errors = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dbell_irq_combiner #(.NUM_WIN(N)) dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pend_i     (pend),
    .comb_en_i  (en),
    .rd_en_i    (rd_en),
    .rd_addr_i  (rd_addr),
    .rd_valid_o (rd_valid),
    .rd_data_o  (rd_data),
    .irq_o      (irq)
  );

  function automatic logic [31:0] exp_word(input int w);
    logic [127:0] t;
    t = '0;
    t[N-1:0] = pend & en;
    return t[w*32 +: 32];
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // driver: called at a negedge, issues a read and queues its expected word
  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input string tag);
    rd_en   = 1'b1;
    rd_addr = a;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic rd_all(input string tag);
    for (int w = 0; w < 4; w++) rd(3'(w), exp_word(w), tag);
  endtask

  task automatic irq_after_edge(input logic exp, input string tag);
    @(negedge clk);
    check(irq == exp, tag, 32'(irq), 32'(exp));
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R7 unexpected valid", rd_data, 32'd0);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(rd_data === e, t, rd_data, e);
      end
    end
  end

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!irq && !rd_valid && rd_data == 0, "R8 reset outputs",
          {rd_data[29:0], rd_valid, irq}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd4, 32'(N - 1), "R4 config word");
    rd(3'd5, 32'd0, "R7 addr 5");
    rd(3'd6, 32'd0, "R7 addr 6");
    rd(3'd7, 32'd0, "R7 addr 7");

    pend = '1; en = '0;
    irq_after_edge(1'b0, "R2 irq with enables off");
    rd_all("R2 status with enables off");

    en = '1;
    foreach (pend[i]) pend[i] = 1'b0;
    begin
      int wins[8] = '{0, 31, 32, 63, 64, 95, 96, N - 1};
      foreach (wins[k]) begin
        pend = '0;
        pend[wins[k]] = 1'b1;
        irq_after_edge(1'b1, "R5 irq rise single window");
        rd(3'(wins[k] / 32), 32'(1) << (wins[k] % 32), "R1 single window word");
        rd_all("R1 other words");
      end
    end

    for (int i = 0; i < N; i++) pend[i] = i[0];
    en = '1;
    rd_all("R1 alternating pending");

    pend = '1;
    for (int i = 0; i < N; i++) en[i] = i[2];
    rd_all("R2 interleaved enables");

    en = '1;
    rd(3'd3, 32'h0000_000F, "R3 unimplemented bits zero");

    pend = '0; pend[10] = 1'b1;
    rd(3'd0, 32'h0000_0400, "R6 held bit read 1");
    rd(3'd0, 32'h0000_0400, "R6 held bit read 2");
    pend[10] = 1'b0;
    rd(3'd0, 32'd0, "R6 cleared after pending drop");

    pend[70] = 1'b1;
    irq_after_edge(1'b1, "R5 irq set");
    pend[70] = 1'b0;
    #1;
    check(irq == 1'b1, "R5 irq held before edge", 32'(irq), 32'd1);
    irq_after_edge(1'b0, "R5 irq fall");

    pend[5] = 1'b1;
    irq_after_edge(1'b1, "R2 irq with enable");
    en[5] = 1'b0;
    irq_after_edge(1'b0, "R2 enable removed");
    rd(3'd0, 32'd0, "R2 enable removed status");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R7 all reads returned", 32'(exp_q.size()), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule